// File: doc/BRIEF.md
# Pin-Driven DAC Code Stepper

This block holds the 12-bit code word of a converter and lets two pulse pins step that word up or down. No serial transfer is needed for a step. A 2-bit step-width setting chooses the part of the word that moves: all 12 bits, the top 10 bits or the top 8 bits. The bits below the chosen part keep their value, so a coarse adjustment never disturbs a fine trim that was loaded earlier.

The step pins are asynchronous to the system clock. They pass through two-flop synchronizers, and their edges are detected in the clock domain. A step is applied when one pin falls while the other pin is low. The pins only act while the chip-select input is high. While chip select is low, a synchronous load port writes the code and the step width in place of the serial path. An asynchronous, active-high clear forces the code to zero, but only while the ready flag is low. The output-enable input is passed through, and it gates a tri-stated copy of the code.

Top module: `dac_code_stepper`

## Requirements
- R1: After rst_ni is released, code_o is 0x000 and the step width is the full word (setting 00).
- R2: While cs_i is low, a clock edge with load_en_i high writes load_code_i into the code and load_mode_i into the step width. The width encoding is 00 for all 12 bits, 01 for bits [11:2], 10 for bits [11:4] and 11 for reserved.
- R3: A falling edge of up_i while down_i is low adds one to the selected slice. code_o changes on the third rising clock edge after the fall.
- R4: A falling edge of down_i while up_i is low subtracts one from the selected slice, with the same latency as R3.
- R5: Each detected edge gives exactly one step, however long the pin then stays low.
- R6: In the 01 and 10 settings, the code bits below the selected slice keep their value across a step.
- R7: A step wraps modulo 2^N inside the N-bit slice and does not carry into or borrow from the preserved low bits.
- R8: A falling edge of one pin while the other pin is high leaves the code unchanged. So do simultaneous falls of both pins.
- R9: While cs_i is low, pin edges leave the code unchanged.
- R10: With step width 11, pin edges leave the code unchanged.
- R11: clr_i high with rdy_i low clears code_o to 0x000 at once, without a clock edge.
- R12: While rdy_i is high, clr_i has no effect on the code.
- R13: oe_o follows oe_i. buf_o drives the code while oe_i is high and is high impedance while oe_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| up_i | input | 1 | Increment pulse pin, asynchronous |
| down_i | input | 1 | Decrement pulse pin, asynchronous |
| cs_i | input | 1 | High: pins may step; low: load path owns the register |
| clr_i | input | 1 | Asynchronous clear, active high |
| rdy_i | input | 1 | Ready flag; high blocks clear |
| load_en_i | input | 1 | Load strobe, honoured while cs_i is low |
| load_code_i | input | 12 | Code value to load |
| load_mode_i | input | 2 | Step-width setting to load |
| oe_i | input | 1 | Output enable |
| code_o | output | 12 | Current code |
| oe_o | output | 1 | Output-enable pass-through |
| buf_o | output | 12 | Tri-stated copy of the code |

## Verification
The bench goes after slice wrap-around: 0xFFE in the 10-bit setting and 0xFF5 in the 8-bit setting. A design that let the carry ripple would corrupt the preserved low bits or the count. It holds a pin low for many cycles after its fall, which catches a level-sensitive stepper that keeps counting. It drives up_i with down_i held high, and then releases down_i. The first case must do nothing, while the release is a legal decrement, so a design that ignores the partner-pin condition, or that wrongly blocks the release, shows a wrong code. It also steps with cs_i low and in the reserved setting, and applies clr_i with rdy_i high and low. A design with a missing gate would change the code where it must hold.

// File: rtl/dac_step_pkg.sv
package dac_step_pkg;
  typedef enum logic [1:0] {
    STEP_FULL = 2'b00,
    STEP_U10  = 2'b01,
    STEP_U8   = 2'b10,
    STEP_RSV  = 2'b11
  } step_mode_e;
endpackage

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/dac_step_detect.sv
module dac_step_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic up_s_i,
  input  logic down_s_i,
  output logic inc_o,
  output logic dec_o
);
  logic up_d_q, down_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_d_q   <= 1'b0;
      down_d_q <= 1'b0;
    end else begin
      up_d_q   <= up_s_i;
      down_d_q <= down_s_i;
    end
  end

  // partner pin must be low before and after the edge
  assign inc_o = up_d_q & ~up_s_i & ~down_s_i & ~down_d_q;
  assign dec_o = down_d_q & ~down_s_i & ~up_s_i & ~up_d_q;

  a_r5_single_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({inc_o, dec_o}));
  a_r5_one_per_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_o |=> !inc_o);
endmodule

// File: rtl/dac_slice_step.sv
module dac_slice_step
  import dac_step_pkg::*;
#(
  parameter int CODE_W   = 12,
  parameter int MID_W    = 10,
  parameter int NARROW_W = 8
) (
  input  logic [CODE_W-1:0] code_i,
  input  step_mode_e        mode_i,
  input  logic              inc_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int NUM_SL = 3;
  logic [CODE_W-1:0] cand [NUM_SL];

  for (genvar g = 0; g < NUM_SL; g++) begin : g_slice
    localparam int SW = (g == 0) ? CODE_W : (g == 1) ? MID_W : NARROW_W;
    logic [SW-1:0] slice, slice_nxt;
    assign slice     = code_i[CODE_W-1 -: SW];
    assign slice_nxt = inc_i ? slice + SW'(1) : slice - SW'(1);
    if (SW == CODE_W) begin : g_whole
      assign cand[g] = slice_nxt;
    end else begin : g_part
      assign cand[g] = {slice_nxt, code_i[CODE_W-SW-1:0]};
    end
  end

  always_comb begin
    unique case (mode_i)
      STEP_FULL: code_o = cand[0];
      STEP_U10:  code_o = cand[1];
      STEP_U8:   code_o = cand[2];
      default:   code_o = code_i;
    endcase
  end
endmodule

// File: rtl/dac_code_stepper.sv
module dac_code_stepper
  import dac_step_pkg::*;
#(
  parameter int CODE_W   = 12,
  parameter int MID_W    = 10,
  parameter int NARROW_W = 8,
  parameter int SYNC_N   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              up_i,
  input  logic              down_i,
  input  logic              cs_i,
  input  logic              clr_i,
  input  logic              rdy_i,
  input  logic              load_en_i,
  input  logic [CODE_W-1:0] load_code_i,
  input  logic [1:0]        load_mode_i,
  input  logic              oe_i,
  output logic [CODE_W-1:0] code_o,
  output logic              oe_o,
  output wire  [CODE_W-1:0] buf_o
);
  localparam int NARROW_LO = CODE_W - NARROW_W;

  logic [1:0]        pins_s;
  logic              inc, dec, step_ok, load_ok;
  logic              arst_n;
  step_mode_e        mode_q;
  logic [CODE_W-1:0] code_q, stepped;

  dac_pin_sync #(.WIDTH(2), .STAGES(SYNC_N)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .async_i({up_i, down_i}), .sync_o(pins_s)
  );

  dac_step_detect u_det (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .up_s_i(pins_s[1]), .down_s_i(pins_s[0]),
    .inc_o(inc), .dec_o(dec)
  );

  dac_slice_step #(.CODE_W(CODE_W), .MID_W(MID_W), .NARROW_W(NARROW_W)) u_step (
    .code_i(code_q), .mode_i(mode_q), .inc_i(inc), .code_o(stepped)
  );

  // clear is blocked while ready is high
  assign arst_n  = rst_ni & ~(clr_i & ~rdy_i);
  assign load_ok = load_en_i & ~cs_i;
  assign step_ok = cs_i & (inc | dec) & (mode_q != STEP_RSV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= STEP_FULL;
    else if (load_ok) mode_q <= step_mode_e'(load_mode_i);
  end

  always_ff @(posedge clk_i or negedge arst_n) begin
    if (!arst_n)      code_q <= '0;
    else if (load_ok) code_q <= load_code_i;
    else if (step_ok) code_q <= stepped;
  end

  assign code_o = code_q;
  assign oe_o   = oe_i;
  assign buf_o  = oe_i ? code_q : 'z;

  a_r3_full_inc: assert property (@(posedge clk_i) disable iff (!arst_n)
    cs_i && inc && !load_en_i && mode_q == STEP_FULL
    |=> code_q == CODE_W'($past(code_q) + CODE_W'(1)));
  a_r6_low_kept: assert property (@(posedge clk_i) disable iff (!arst_n)
    cs_i && (inc || dec) && mode_q == STEP_U8
    |=> code_q[NARROW_LO-1:0] == $past(code_q[NARROW_LO-1:0]));
  a_r9_cs_low_hold: assert property (@(posedge clk_i) disable iff (!arst_n)
    !cs_i && !load_en_i |=> $stable(code_q));
  a_r10_rsv_hold: assert property (@(posedge clk_i) disable iff (!arst_n)
    mode_q == STEP_RSV && !load_en_i |=> $stable(code_q));
  a_r13_oe_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_o == oe_i);
endmodule

// File: tb/dac_code_stepper_bench.sv
module dac_code_stepper_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up = 1'b0, down = 1'b0, cs = 1'b0, clr = 1'b0, rdy = 1'b0;
  logic        load_en = 1'b0, oe = 1'b0;
  logic [11:0] load_code = '0;
  logic [1:0]  load_mode = '0;
  logic [11:0] code, buf_w;
  logic        oe_out;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [11:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  dac_code_stepper u_dac_code_stepper (
    .clk_i(clk), .rst_ni(rst_n), .up_i(up), .down_i(down), .cs_i(cs),
    .clr_i(clr), .rdy_i(rdy), .load_en_i(load_en), .load_code_i(load_code),
    .load_mode_i(load_mode), .oe_i(oe), .code_o(code), .oe_o(oe_out),
    .buf_o(buf_w)
  );

  // monitor: compares code_o with each queued expectation
  initial begin
    forever begin
      wait (exp_q.size() > 0);
      begin
        logic [11:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (code !== e) begin
          fails++;
          $display("FAIL %s: code_o=%h expected %h", t, code, e);
        end
      end
    end
  end

  task automatic expect_code(input logic [11:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
    #1;
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [11:0] v, input logic [1:0] m);
    cs = 1'b0; load_code = v; load_mode = m; load_en = 1'b1;
    clks(1);
    load_en = 1'b0; cs = 1'b1;
    clks(1);
  endtask

  task automatic pulse_up();
    up = 1'b1; clks(4); up = 1'b0; clks(5);
  endtask

  task automatic pulse_down();
    down = 1'b1; clks(4); down = 1'b0; clks(5);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    clks(3); rst_n = 1'b1; clks(2);
    expect_code(12'h000, "R1 reset value");

    // R3 latency: unchanged after two edges, changed on the third
    load(12'h0FF, 2'b00);
    expect_code(12'h0FF, "R2 load full");
    up = 1'b1; clks(4); up = 1'b0;
    clks(2); expect_code(12'h0FF, "R3 not before third edge");
    clks(1); expect_code(12'h100, "R3 increment on third edge");
    clks(20); expect_code(12'h100, "R5 single step while held low");
    pulse_down(); expect_code(12'h0FF, "R4 decrement full");
    load(12'h000, 2'b00); pulse_down();
    expect_code(12'hFFF, "R7 full word wraps down");

    load(12'h89E, 2'b10);
    pulse_up(); expect_code(12'h8AE, "R6 8-bit slice inc keeps low bits");
    pulse_down(); pulse_down(); expect_code(12'h88E, "R6 8-bit slice dec");
    load(12'hFF5, 2'b10); pulse_up();
    expect_code(12'h005, "R7 8-bit slice wraps, low nibble kept");
    load(12'h003, 2'b01); pulse_up();
    expect_code(12'h007, "R6 10-bit slice inc keeps low bits");
    load(12'hFFE, 2'b01); pulse_up();
    expect_code(12'h002, "R7 10-bit slice wraps, no carry");

    // R8: up falls while down high, then down release is a legal decrement
    load(12'h100, 2'b00);
    down = 1'b1; clks(4); pulse_up();
    expect_code(12'h100, "R8 up fall with down high ignored");
    down = 1'b0; clks(5);
    expect_code(12'h0FF, "R4 down release with up low decrements");
    up = 1'b1; down = 1'b1; clks(4); up = 1'b0; down = 1'b0; clks(6);
    expect_code(12'h0FF, "R8 simultaneous falls ignored");

    cs = 1'b0; pulse_up(); pulse_down();
    expect_code(12'h0FF, "R9 cs low ignores pins");
    cs = 1'b1; clks(4);
    expect_code(12'h0FF, "R9 no late step after cs rises");

    load(12'h123, 2'b11); pulse_up(); pulse_down();
    expect_code(12'h123, "R10 reserved setting ignores pins");

    rdy = 1'b1; clr = 1'b1; #2;
    expect_code(12'h123, "R12 clear blocked by ready");
    clks(3); expect_code(12'h123, "R12 clear still blocked");
    clr = 1'b0; rdy = 1'b0; clks(1);
    clr = 1'b1; #2;
    expect_code(12'h000, "R11 asynchronous clear");
    clks(1); clr = 1'b0; clks(1);

    load(12'h5A5, 2'b00);
    oe = 1'b0; #1;
    checks++;
    if (oe_out !== 1'b0) begin
      fails++; $display("FAIL R13: oe_o=%b expected 0", oe_out);
    end
    oe = 1'b1; #1;
    checks++;
    if (oe_out !== 1'b1 || buf_w !== 12'h5A5) begin
      fails++; $display("FAIL R13: oe_o=%b buf_o=%h expected 1 5a5", oe_out, buf_w);
    end

    clks(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule